// File: doc/BRIEF.md
# Atomic GPIO Set/Clear Output Port

This block drives one bank of output pins (16 by default) from a small 32-bit register bus. Software can load every pin at once through a read/write data register. It can also change chosen pins with one bus write and no read step, through three write-only ports: a combined set/reset port, a clear-only port and a toggle port. Each write updates the pins at the clock edge where it is presented, so no other agent can land a write between a read and a write-back.

The bus has an access enable, a write strobe, a byte address, write data, registered read data and a registered ready. Ready goes high in the cycle after any access. Read data appears in that same cycle and is zero for anything that is not a read of the data register.

The port map is fixed: 0x00 is the data register, 0x04 is set/reset, 0x08 is clear-only and 0x0C is toggle. Every other address decodes to nothing, including addresses that are not word-aligned.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset, the pin outputs are all zero, ready is low and read data is zero.
- R2: A write to offset 0x00 replaces all pin values with write data bits [15:0]. A read of 0x00 returns the pins in bits [15:0], with bits [31:16] zero.
- R3: A write to offset 0x04 drives pin n high where write data bit n is 1 and drives pin n low where bit n+16 is 1. Pins whose two bits are both 0 keep their value. One write may set some pins and clear others.
- R4: In a write to 0x04 where bit n and bit n+16 are both 1, pin n ends high.
- R5: A write to offset 0x08 drives low every pin n whose write data bit n is 1. Bits [31:16] of that write have no effect.
- R6: A write to offset 0x0C inverts every pin n whose write data bit n is 1. Bits [31:16] of that write have no effect.
- R7: Every write changes the pins at the clock edge where it is presented, so the new value is visible in the next cycle. Back-to-back writes in consecutive cycles each take effect in turn.
- R8: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R9: Any offset other than 0x00, 0x04, 0x08 and 0x0C reads as zero, and writes to it leave the pins unchanged. Unaligned offsets such as 0x02 count as unmapped.
- R10: Ready is high in exactly the cycle after each access cycle and low otherwise. Read data is valid while ready is high and zero when no read of 0x00 was made.
- R11: Reads and idle cycles never change the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Access completed in the previous cycle |
| pins_o | output | 16 | Pin output values |

## Verification
The hardest case to reach is a set/reset write that raises the set bit and the clear bit of the same pin while other pins in that write are only set or only cleared. It gets harder still when that write follows another write to a different port in the very next cycle. The stimulus builds such words on purpose: overlapping masks, then a run of consecutive writes with no idle cycle between them that walks across all four ports. A long pseudo-random run then mixes mapped, unmapped and unaligned offsets with reads and idles. A behavioural model checks pins, ready and read data after every clock.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_SETRST,
        SEL_CLR,
        SEL_TOGGLE
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_atomic_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] OFF_DATA   = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_SETRST = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_CLR    = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFF_TOGGLE = ADDR_W'(8'h0C);

    // Full-width compare: misaligned or out-of-range offsets select nothing.
    always_comb begin
        case (addr)
            OFF_DATA:   sel = SEL_DATA;
            OFF_SETRST: sel = SEL_SETRST;
            OFF_CLR:    sel = SEL_CLR;
            OFF_TOGGLE: sel = SEL_TOGGLE;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_pin_update.sv
module gpio_pin_update
    import gpio_atomic_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32
) (
    input  logic [PINS-1:0]   cur,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   nxt
);
    localparam int HALF = DATA_W / 2;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic up_b;
        logic dn_b;
        logic nb;
        assign up_b = wdata[i];
        assign dn_b = wdata[HALF+i];

        always_comb begin
            nb = cur[i];
            if (wr) begin
                unique case (sel)
                    SEL_DATA:   nb = up_b;
                    // set outranks clear when both are requested
                    SEL_SETRST: nb = up_b | (cur[i] & ~dn_b);
                    SEL_CLR:    nb = cur[i] & ~up_b;
                    SEL_TOGGLE: nb = cur[i] ^ up_b;
                    SEL_NONE:   nb = cur[i];
                endcase
            end
        end

        assign nxt[i] = nb;
    end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_atomic_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [PINS-1:0]   pins,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    localparam int PAD = DATA_W - PINS;

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (en && !we && sel == SEL_DATA) rd_val = {{PAD{1'b0}}, pins};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            ready <= 1'b0;
        end else begin
            rdata <= rd_val;
            ready <= en;
        end
    end
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_atomic_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [PINS-1:0]   pins_o
);
    reg_sel_e        sel;
    logic            wr;
    logic [PINS-1:0] pins_q;
    logic [PINS-1:0] pins_d;

    assign wr = bus_en & bus_we;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_pin_update #(.PINS(PINS), .DATA_W(DATA_W)) u_upd (
        .cur   (pins_q),
        .wr    (wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .nxt   (pins_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    gpio_read_path #(.PINS(PINS), .DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bus_en),
        .we    (bus_we),
        .sel   (sel),
        .pins  (pins_q),
        .rdata (bus_rdata),
        .ready (bus_ready)
    );

    assign pins_o = pins_q;
endmodule

// File: rtl/gpio_atomic_checker.sv
module gpio_atomic_checker #(
    parameter int PINS   = 16,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic [PINS-1:0]   pins_o
);
    localparam int HALF = DATA_W / 2;

    logic wr_sr, wr_clr, wr_tog, rd_wo;
    assign wr_sr  = bus_en && bus_we && bus_addr == ADDR_W'(8'h04);
    assign wr_clr = bus_en && bus_we && bus_addr == ADDR_W'(8'h08);
    assign wr_tog = bus_en && bus_we && bus_addr == ADDR_W'(8'h0C);
    assign rd_wo  = bus_en && !bus_we && bus_addr != ADDR_W'(8'h00);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sr |=> ((pins_o & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    assert_setrst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sr |=> ((pins_o & $past(bus_wdata[HALF+PINS-1:HALF]) & ~$past(bus_wdata[PINS-1:0])) == '0));

    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pins_o & $past(bus_wdata[PINS-1:0])) == '0));

    assert_toggle_inverts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tog |=> (pins_o == ($past(pins_o) ^ $past(bus_wdata[PINS-1:0]))));

    assert_no_write_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> $stable(pins_o));

    assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> bus_ready);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !bus_ready);

    assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |=> (bus_rdata == '0));
endmodule

bind gpio_atomic_port gpio_atomic_checker #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .pins_o    (pins_o)
);

// File: tb/sim_gpio_atomic_port.sv
`timescale 1ns/100ps
module sim_gpio_atomic_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [15:0] pins_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] m_pins = '0;

    always #2.5 clk = ~clk;

    gpio_atomic_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pins_o(pins_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input logic en, input logic we, input logic [5:0] a,
                        input logic [31:0] d, input string tag);
        logic [15:0] np;
        logic [31:0] nr;
        np = m_pins;
        nr = '0;
        if (en && we) begin
            case (a)
                6'h00: np = d[15:0];
                6'h04: np = (m_pins & ~d[31:16]) | d[15:0];
                6'h08: np = m_pins & ~d[15:0];
                6'h0C: np = m_pins ^ d[15:0];
                default: np = m_pins;
            endcase
        end
        if (en && !we && a == 6'h00) nr = {16'h0, m_pins};
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        m_pins = np;
        chk(tag, "pins", {16'h0, pins_o}, {16'h0, np});
        chk(tag, "ready", {31'h0, bus_ready}, {31'h0, en});
        chk(tag, "rdata", bus_rdata, nr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pins", {16'h0, pins_o}, 32'h0);
        chk("R1", "ready", {31'h0, bus_ready}, 32'h0);
        chk("R1", "rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        step(0, 0, 6'h00, 32'h0, "R11");
        // R2: direct load and read back
        step(1, 1, 6'h00, 32'hFFFF_A5C3, "R2");
        step(1, 0, 6'h00, 32'h0, "R2");
        // R3: mixed set and clear in one write
        step(1, 1, 6'h04, 32'h00C3_0F00, "R3");
        step(1, 0, 6'h00, 32'h0, "R3");
        // R4: same pins set and cleared at once
        step(1, 1, 6'h04, 32'hFFFF_0011, "R4");
        step(1, 0, 6'h00, 32'h0, "R4");
        // R5: clear-only; high half has no effect
        step(1, 1, 6'h00, 32'h0000_FFFF, "R5");
        step(1, 1, 6'h08, 32'hFFFF_00FF, "R5");
        // R6: toggle; high half has no effect
        step(1, 1, 6'h0C, 32'hFFFF_F0F0, "R6");
        step(1, 1, 6'h0C, 32'h0000_FFFF, "R6");
        // R7: back-to-back writes across all ports
        step(1, 1, 6'h00, 32'h0000_1234, "R7");
        step(1, 1, 6'h04, 32'h1200_8001, "R7");
        step(1, 1, 6'h08, 32'h0000_0030, "R7");
        step(1, 1, 6'h0C, 32'h0000_FF00, "R7");
        step(1, 1, 6'h04, 32'h8001_8001, "R7");
        // R8: write-only ports read zero
        step(1, 0, 6'h04, 32'h0, "R8");
        step(1, 0, 6'h08, 32'h0, "R8");
        step(1, 0, 6'h0C, 32'h0, "R8");
        // R9: unmapped and unaligned offsets
        step(1, 1, 6'h10, 32'hFFFF_FFFF, "R9");
        step(1, 1, 6'h02, 32'h0000_FFFF, "R9");
        step(1, 1, 6'h3C, 32'hFFFF_0000, "R9");
        step(1, 0, 6'h10, 32'h0, "R9");
        step(1, 0, 6'h01, 32'h0, "R9");
        // R10/R11: idles and reads between accesses
        step(0, 1, 6'h00, 32'hFFFF_FFFF, "R10");
        step(1, 0, 6'h00, 32'h0, "R10");
        step(0, 0, 6'h0C, 32'hFFFF_FFFF, "R11");
        step(1, 0, 6'h0C, 32'hFFFF_FFFF, "R11");
        // pseudo-random mix
        begin
            logic [31:0] lfsr;
            logic [5:0]  offs [6];
            offs[0] = 6'h00; offs[1] = 6'h04; offs[2] = 6'h08;
            offs[3] = 6'h0C; offs[4] = 6'h10; offs[5] = 6'h06;
            lfsr = 32'hACE1_1357;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                step(lfsr[3:0] != 4'h0, lfsr[4] | lfsr[5], offs[lfsr[10:8] % 6],
                     {lfsr[15:0], lfsr[31:16]} ^ {lfsr[23:8], lfsr[7:0], lfsr[31:24]}, "R7");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule